// File: doc/BRIEF.md
# System-Control Coprocessor Register Front End

This block sits beside a processor core and serves the instruction fields that the core has already decoded for its system-control coprocessor. A request carries the instruction class, a direction bit, the primary opcode, the main register number, the secondary register number, the secondary opcode, the core's privilege level and the write data. In the following cycle the block answers with read data and one of two outcomes. Either the access completed, or the core must take the undefined-instruction trap.

Register 0 is an identification register and cannot be written. The secondary opcode decides whether it returns the device identification word or the cache-description word. Main register numbers 1 to `NCTL` each select one plain writable control word, which is held as storage. Any other field combination that the block cannot give a meaning to completes with zero read data and no state change. Such an access also raises a flag marking it as unpredictable.

Top module: `sysctl_cop`

## Requirements
- R1: After reset, `rsp_vld` is 0, and every control word reads back as zero.
- R2: A request whose class is not a register transfer answers with `rsp_trap`=1, `rsp_done`=0 and zero data, at any privilege level. The class encodings are: 0 for register transfer, 1 for data operation, 2 for load to the coprocessor and 3 for store from it. Such a request changes no state.
- R3: A register transfer with `req_priv`=0 answers with `rsp_trap`=1 and changes no control word.
- R4: A privileged read (`req_dir`=1) of main register 0 with primary opcode 0 and secondary opcode 1 returns the `CACHE_WORD` parameter.
- R5: A privileged read of main register 0 with primary opcode 0 and any secondary opcode other than 1 returns the identification word. Its layout is: implementer 0x41 in bits 31:24, revision 0x1 in bits 23:20, architecture 0x2 in bits 19:16, part 0x920 in bits 15:4, and the `LAYOUT_REV` parameter in bits 3:0.
- R6: A privileged write (`req_dir`=0) with primary opcode 0 to main register n, where 1 ≤ n ≤ `NCTL`, stores `req_wdata` in control word n. A read in the next request returns that value. Each control word is independent of the others.
- R7: Three kinds of privileged transfer complete with `rsp_done`=1, `rsp_odd`=1 and zero read data, and change no state: any transfer with a non-zero primary opcode, a write to main register 0, and a transfer to a main register above `NCTL`. A write to main register 0 leaves both identification words unchanged.
- R8: Each request gives exactly one response, in the next cycle. In that response exactly one of `rsp_done` and `rsp_trap` is set. Legal accesses leave `rsp_odd` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request present this cycle |
| req_cls | input | 2 | Instruction class (0 transfer, 1 data op, 2 load, 3 store) |
| req_dir | input | 1 | 1 = read into core, 0 = write from core |
| req_op1 | input | 3 | Primary opcode field |
| req_crn | input | 4 | Main register number |
| req_crm | input | 4 | Secondary register number |
| req_op2 | input | 3 | Secondary opcode field |
| req_priv | input | 1 | Core is in a privileged mode |
| req_wdata | input | 32 | Write data |
| rsp_vld | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data |
| rsp_done | output | 1 | Access completed |
| rsp_trap | output | 1 | Undefined-instruction trap |
| rsp_odd | output | 1 | Access was unpredictable and had no effect |

## Verification
The assertions assume that the request fields are known whenever `req_vld` is high. They also assume that `req_vld` stays low during reset, so the response register has a defined history to refer back to. The bench drives every request on the falling edge and holds it for exactly one cycle. It lowers `req_vld` between requests and while reset is active. The control-word checks read back through ordinary privileged reads, and those reads are themselves legal requests.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  typedef enum logic [1:0] {
    CLS_XFER  = 2'd0,
    CLS_DATA  = 2'd1,
    CLS_LOAD  = 2'd2,
    CLS_STORE = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_ID    = 2'd1,
    SRC_CACHE = 2'd2,
    SRC_CTL   = 2'd3
  } src_e;

  localparam logic [7:0]  ID_IMPL = 8'h41;
  localparam logic [3:0]  ID_SPEC = 4'h1;
  localparam logic [3:0]  ID_ARCH = 4'h2;
  localparam logic [11:0] ID_PART = 12'h920;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int NCTL = 3,
  parameter int IW   = 2
) (
  input  logic          vld,
  input  logic [1:0]    cls,
  input  logic          dir,
  input  logic [2:0]    op1,
  input  logic [3:0]    crn,
  input  logic [2:0]    op2,
  input  logic          priv,
  output logic          trap,
  output logic          odd,
  output logic          wr_en,
  output logic [IW-1:0] idx,
  output src_e          src
);
  logic [3:0] crn_m1;
  assign crn_m1 = crn - 4'd1;

  always_comb begin
    trap  = 1'b0;
    odd   = 1'b0;
    wr_en = 1'b0;
    src   = SRC_ZERO;
    idx   = crn_m1[IW-1:0];
    if (vld) begin
      if (cls != CLS_XFER || !priv) begin
        trap = 1'b1;
      end else if (op1 != 3'd0) begin
        odd = 1'b1;
      end else if (crn == 4'd0) begin
        if (dir) src = (op2 == 3'd1) ? SRC_CACHE : SRC_ID;
        else     odd = 1'b1;
      end else if (int'(crn) <= NCTL) begin
        if (dir) src = SRC_CTL;
        else     wr_en = 1'b1;
      end else begin
        odd = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sysctl_ctlregs.sv
module sysctl_ctlregs #(
  parameter int NCTL = 3,
  parameter int IW   = 2,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [NCTL-1:0][DW-1:0] regs_q;
  logic [NCTL-1:0][DW-1:0] regs_d;
  logic [NCTL-1:0]         ce;

  for (genvar g = 0; g < NCTL; g++) begin : g_word
    assign ce[g] = wr_en && (int'(idx) == g);
    always_comb regs_d[g] = ce[g] ? wdata : regs_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs_q[g] <= '0;
      else if (ce[g]) regs_q[g] <= regs_d[g];
    end
  end

  assign rdata = (int'(idx) < NCTL) ? regs_q[idx] : '0;

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs_q[$past(idx)] == $past(wdata));
endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
  import sysctl_pkg::*;
#(
  parameter int          NCTL       = 3,
  parameter logic [3:0]  LAYOUT_REV = 4'h3,
  parameter logic [31:0] CACHE_WORD = 32'h0D17_2172
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_vld,
  input  logic [1:0]  req_cls,
  input  logic        req_dir,
  input  logic [2:0]  req_op1,
  input  logic [3:0]  req_crn,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op2,
  input  logic        req_priv,
  input  logic [31:0] req_wdata,
  output logic        rsp_vld,
  output logic [31:0] rsp_rdata,
  output logic        rsp_done,
  output logic        rsp_trap,
  output logic        rsp_odd
);
  localparam int IW = (NCTL > 1) ? $clog2(NCTL) : 1;
  localparam logic [31:0] ID_WORD = {ID_IMPL, ID_SPEC, ID_ARCH, ID_PART, LAYOUT_REV};

  logic          dec_trap, dec_odd, dec_wr;
  logic [IW-1:0] dec_idx;
  src_e          dec_src;
  logic [31:0]   ctl_rd, rd_mux;
  logic          crm_unused;

  assign crm_unused = ^req_crm;

  sysctl_decode #(.NCTL(NCTL), .IW(IW)) i_dec (
    .vld(req_vld), .cls(req_cls), .dir(req_dir), .op1(req_op1),
    .crn(req_crn), .op2(req_op2), .priv(req_priv),
    .trap(dec_trap), .odd(dec_odd), .wr_en(dec_wr), .idx(dec_idx), .src(dec_src)
  );

  sysctl_ctlregs #(.NCTL(NCTL), .IW(IW), .DW(32)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(dec_wr), .idx(dec_idx),
    .wdata(req_wdata), .rdata(ctl_rd)
  );

  always_comb begin
    unique case (dec_src)
      SRC_ID:    rd_mux = ID_WORD;
      SRC_CACHE: rd_mux = CACHE_WORD;
      SRC_CTL:   rd_mux = ctl_rd;
      default:   rd_mux = '0;
    endcase
  end

  logic        vld_d, done_d, trap_d, odd_d;
  logic [31:0] data_d;

  always_comb begin
    vld_d  = req_vld;
    trap_d = dec_trap;
    done_d = req_vld && !dec_trap;
    odd_d  = dec_odd;
    data_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_odd   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_vld   <= vld_d;
      rsp_done  <= done_d;
      rsp_trap  <= trap_d;
      rsp_odd   <= odd_d;
      rsp_rdata <= data_d;
    end
  end

  a_r8_one_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> (rsp_done ^ rsp_trap));
  a_r2_class_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_cls != CLS_XFER) |=> (rsp_trap && rsp_rdata == 32'd0));
  a_r3_user_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_priv) |=> rsp_trap);
  a_r7_odd_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    dec_odd |-> !dec_wr);
  a_r7_odd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_odd |-> (rsp_done && rsp_rdata == 32'd0));
  a_r4_cache_word: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_priv && req_cls == CLS_XFER && req_dir && req_op1 == 3'd0
     && req_crn == 4'd0 && req_op2 == 3'd1) |=> rsp_rdata == CACHE_WORD);
endmodule

// File: tb/test_sysctl_cop.sv
module test_sysctl_cop;
  localparam logic [3:0]  REV   = 4'h5;
  localparam logic [31:0] CWORD = 32'h1234_ABCD;
  localparam logic [31:0] IDW   = {8'h41, 4'h1, 4'h2, 12'h920, REV};

  logic clk = 1'b0;
  logic rst_n;
  logic req_vld, req_dir, req_priv;
  logic [1:0] req_cls;
  logic [2:0] req_op1, req_op2;
  logic [3:0] req_crn, req_crm;
  logic [31:0] req_wdata;
  logic rsp_vld, rsp_done, rsp_trap, rsp_odd;
  logic [31:0] rsp_rdata;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  sysctl_cop #(.NCTL(3), .LAYOUT_REV(REV), .CACHE_WORD(CWORD)) i_sysctl_cop (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_cls(req_cls),
    .req_dir(req_dir), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
    .req_op2(req_op2), .req_priv(req_priv), .req_wdata(req_wdata),
    .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .rsp_trap(rsp_trap), .rsp_odd(rsp_odd)
  );

  task automatic chk(input string req, input logic [34:0] act, input logic [34:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one request, one cycle; response sampled on the next falling edge
  task automatic xfer(input logic [1:0] cls, input logic dir, input logic [2:0] op1,
                      input logic [3:0] crn, input logic [3:0] crm, input logic [2:0] op2,
                      input logic priv, input logic [31:0] wd);
    @(negedge clk);
    req_vld = 1'b1; req_cls = cls; req_dir = dir; req_op1 = op1;
    req_crn = crn; req_crm = crm; req_op2 = op2; req_priv = priv; req_wdata = wd;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  // packed expectation: {done, trap, odd, data}
  function automatic logic [34:0] rsp();
    return {rsp_done, rsp_trap, rsp_odd, rsp_rdata};
  endfunction

  task automatic t_reset;
    chk("R1 rsp_vld", {34'd0, rsp_vld}, 35'd0);
    for (int n = 1; n <= 3; n++) begin
      xfer(2'd0, 1'b1, 3'd0, 4'(n), 4'd0, 3'd0, 1'b1, 32'd0);
      chk("R1 ctl zero", rsp(), {3'b100, 32'd0});
    end
  endtask

  task automatic t_ident;
    xfer(2'd0, 1'b1, 3'd0, 4'd0, 4'd0, 3'd1, 1'b1, 32'd0);
    chk("R4 cache word", rsp(), {3'b100, CWORD});
    for (int o = 0; o < 8; o++) begin
      if (o != 1) begin
        xfer(2'd0, 1'b1, 3'd0, 4'd0, 4'd0, 3'(o), 1'b1, 32'd0);
        chk("R5 id word", rsp(), {3'b100, IDW});
      end
    end
  endtask

  task automatic t_ctl;
    xfer(2'd0, 1'b0, 3'd0, 4'd1, 4'd0, 3'd0, 1'b1, 32'hA5A5_0001);
    chk("R8 write done", rsp(), {3'b100, 32'd0});
    xfer(2'd0, 1'b0, 3'd0, 4'd3, 4'd0, 3'd0, 1'b1, 32'hFFFF_0003);
    xfer(2'd0, 1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 1'b1, 32'd0);
    chk("R6 ctl1", rsp(), {3'b100, 32'hA5A5_0001});
    xfer(2'd0, 1'b1, 3'd0, 4'd2, 4'd0, 3'd0, 1'b1, 32'd0);
    chk("R6 ctl2 untouched", rsp(), {3'b100, 32'd0});
    xfer(2'd0, 1'b1, 3'd0, 4'd3, 4'd0, 3'd0, 1'b1, 32'd0);
    chk("R6 ctl3", rsp(), {3'b100, 32'hFFFF_0003});
  endtask

  task automatic t_traps;
    for (int c = 1; c < 4; c++) begin
      xfer(2'(c), 1'b0, 3'd0, 4'd1, 4'd0, 3'd0, 1'b1, 32'h0BAD_0000);
      chk("R2 class trap", rsp(), {3'b010, 32'd0});
      xfer(2'(c), 1'b1, 3'd0, 4'd0, 4'd0, 3'd0, 1'b0, 32'd0);
      chk("R2 class trap user", rsp(), {3'b010, 32'd0});
    end
    xfer(2'd0, 1'b0, 3'd0, 4'd1, 4'd0, 3'd0, 1'b0, 32'h0BAD_0001);
    chk("R3 user write trap", {1'b0, rsp_trap, 33'd0}, {1'b0, 1'b1, 33'd0});
    xfer(2'd0, 1'b1, 3'd0, 4'd0, 4'd0, 3'd0, 1'b0, 32'd0);
    chk("R3 user read trap", {1'b0, rsp_trap, rsp_done, 32'd0}, {3'b010, 32'd0});
    xfer(2'd0, 1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 1'b1, 32'd0);
    chk("R3 R2 ctl1 unchanged", rsp(), {3'b100, 32'hA5A5_0001});
  endtask

  task automatic t_odd;
    xfer(2'd0, 1'b1, 3'd2, 4'd1, 4'd0, 3'd0, 1'b1, 32'd0);
    chk("R7 op1 read", rsp(), {3'b101, 32'd0});
    xfer(2'd0, 1'b0, 3'd1, 4'd2, 4'd0, 3'd0, 1'b1, 32'h0BAD_0002);
    chk("R7 op1 write", rsp(), {3'b101, 32'd0});
    xfer(2'd0, 1'b1, 3'd0, 4'd2, 4'd0, 3'd0, 1'b1, 32'd0);
    chk("R7 ctl2 unchanged", rsp(), {3'b100, 32'd0});
    xfer(2'd0, 1'b0, 3'd0, 4'd0, 4'd0, 3'd1, 1'b1, 32'h0BAD_0003);
    chk("R7 reg0 write", rsp(), {3'b101, 32'd0});
    xfer(2'd0, 1'b1, 3'd0, 4'd0, 4'd0, 3'd1, 1'b1, 32'd0);
    chk("R7 cache kept", rsp(), {3'b100, CWORD});
    xfer(2'd0, 1'b1, 3'd0, 4'd0, 4'd0, 3'd0, 1'b1, 32'd0);
    chk("R7 id kept", rsp(), {3'b100, IDW});
    xfer(2'd0, 1'b1, 3'd0, 4'd4, 4'd0, 3'd0, 1'b1, 32'd0);
    chk("R7 unimpl read", rsp(), {3'b101, 32'd0});
    xfer(2'd0, 1'b0, 3'd0, 4'd15, 4'd0, 3'd0, 1'b1, 32'h0BAD_0004);
    chk("R7 unimpl write", rsp(), {3'b101, 32'd0});
    xfer(2'd0, 1'b1, 3'd0, 4'd3, 4'd0, 3'd0, 1'b1, 32'd0);
    chk("R7 ctl3 unchanged", rsp(), {3'b100, 32'hFFFF_0003});
  endtask

  task automatic t_timing;
    xfer(2'd0, 1'b1, 3'd0, 4'd0, 4'd0, 3'd0, 1'b1, 32'd0);
    @(negedge clk);
    chk("R8 single response", {34'd0, rsp_vld}, 35'd0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; req_cls = '0; req_dir = 1'b0; req_op1 = '0;
    req_crn = '0; req_crm = '0; req_op2 = '0; req_priv = 1'b0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ident;
    t_ctl;
    t_traps;
    t_odd;
    t_timing;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule